// File: doc/BRIEF.md
# EDID Block Fetch Sequencer

This block reads a display's identification data over a display data channel by driving a command engine that performs the bit-level I2C transfers. It reads the 128-byte base block first. The engine runs one read command at a time. For each command the sequencer empties the engine's receive FIFO, then issues a segment, a low offset byte and a byte count. It waits for the engine's busy flag to drop and then pops the returned bytes into a local byte store.

Each block is checked by summing its bytes modulo 256. A block that does not sum to zero is read again in full. The base block also states how many extension blocks follow. The sequencer reads that many, capped at a parameter limit, and stops quietly at the first extension that never passes its check. When it finishes it gives a one-cycle done pulse, a status code and the number of extensions captured. The host then reads the captured bytes through a read port on the store.

Top module: `edid_fetch_seq`

## Requirements
- R1: Block k is read from byte address k*128 as a series of commands. Each command asks for min(CHUNK_BYTES, bytes left in the block) bytes, which is 16 with the defaults. The address of each command is the previous address plus the previous count.
- R2: `fifo_clear` is high for exactly the one cycle before every cycle in which `cmd_valid` is high.
- R3: Each command presents `cmd_segment` = byte address >> 8 and `cmd_offset` = byte address mod 256.
- R4: After busy drops, exactly `cmd_len` pops (`fifo_rd`) follow, and `fifo_rd` is never high while `eng_busy` is high. The byte taken on each pop is stored at its byte address. That byte appears on `rd_data` one clock after `rd_addr` is applied.
- R5: A wait in which `eng_busy` stays high for TIMEOUT_US*CYC_PER_US consecutive cycles ends the fetch with status 1 (timeout), and no further command is issued. A wait one cycle shorter continues normally.
- R6: A block whose 128 bytes do not sum to 0 modulo 256 is read again from its first byte, for at most 2 retries (3 attempts in all). Each attempt overwrites the stored bytes.
- R7: If the base block fails all attempts, the fetch ends with status 2 (checksum failure) and `ext_count` = 0.
- R8: The extension count is byte 126 of the base block, clamped to MAX_EXT (4). Extensions 1..n are read in ascending order, and `ext_count` = n on success, with status 0.
- R9: If extension block k fails all its attempts, fetching stops with status 0 (ok) and `ext_count` = k-1.
- R10: After reset, `done`, `cmd_valid`, `fifo_clear` and `fifo_rd` are low and `ext_count` and `status` are 0. `done` lasts one cycle, with `status` and `ext_count` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch (accepted when idle) |
| done | output | 1 | One-cycle end-of-fetch pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 base-block checksum failure |
| ext_count | output | EXT_W (3) | Extension blocks captured |
| fifo_clear | output | 1 | Empties the engine FIFO |
| cmd_valid | output | 1 | Read command strobe |
| cmd_segment | output | 8 | Segment number of the command |
| cmd_offset | output | 8 | Low byte of the byte address |
| cmd_len | output | LEN_W (5) | Bytes requested |
| eng_busy | input | 1 | Engine busy flag |
| fifo_rd | output | 1 | Pops one byte from the engine FIFO |
| fifo_data | input | 8 | Head byte of the engine FIFO |
| rd_addr | input | ADDR_W (10) | Host read address into the store |
| rd_data | output | 8 | Stored byte |

## Verification
The assertions assume the engine raises `eng_busy` at the same clock edge that samples `cmd_valid` and holds it high until the requested bytes are in its FIFO. Under that assumption no pop overlaps busy, and the first FIFO byte is already at the head when busy drops. The bench's engine model keeps to this. It pushes a whole chunk and raises busy at the command edge, then lowers busy after a chosen delay. It only stalls forever in the timeout cases, and clears that stall before the next fetch starts.

// File: rtl/edid_fetch_pkg.sv
package edid_fetch_pkg;

   localparam int unsigned EDID_BLOCK_BYTES = 128;
   localparam int unsigned EXT_COUNT_INDEX  = 126;

   typedef enum logic [1:0] {
      FETCH_OK       = 2'd0,
      FETCH_TIMEOUT  = 2'd1,
      FETCH_CSUM_BAD = 2'd2
   } fetch_status_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_CLEAR,
      SQ_ISSUE,
      SQ_WAIT,
      SQ_DRAIN,
      SQ_CHECK
   } seq_state_e;

endpackage

// File: rtl/edid_cmd_former.sv
module edid_cmd_former
   import edid_fetch_pkg::*;
#(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned LEN_W       = 5,
   parameter int unsigned CHUNK_BYTES = 16
) (
   input  logic [ADDR_W-1:0] byte_addr,
   input  logic [6:0]        in_block,
   output logic [7:0]        segment,
   output logic [7:0]        offset,
   output logic [LEN_W-1:0]  len
);

   logic [8:0] remaining;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("edid_cmd_former: ADDR_W must be at least 8");
   end

   assign remaining = 9'(EDID_BLOCK_BYTES) - {2'b00, in_block};
   assign len = (remaining < 9'(CHUNK_BYTES)) ? LEN_W'(remaining)
                                              : LEN_W'(CHUNK_BYTES);
   assign offset = byte_addr[7:0];

   if (ADDR_W > 8) begin : g_seg_wide
      assign segment = 8'(byte_addr >> 8);
   end else begin : g_seg_none
      assign segment = 8'd0;
   end

endmodule

// File: rtl/edid_wait_timer.sv
module edid_wait_timer #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   if (LIMIT < 2) begin : g_bad_limit
      $error("edid_wait_timer: LIMIT must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (run) begin
         cnt <= cnt + CW'(1);
      end else begin
         cnt <= '0;
      end
   end

   assign expired = run && (cnt == CW'(LIMIT - 1));

   a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < CW'(LIMIT)));

endmodule

// File: rtl/edid_block_store.sv
module edid_block_store #(
   parameter int unsigned DEPTH    = 640,
   parameter int unsigned AW       = 10,
   parameter bit          REG_READ = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];

   if (DEPTH > (1 << AW)) begin : g_bad_depth
      $error("edid_block_store: DEPTH exceeds address range");
   end

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   if (REG_READ) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdata <= 8'd0;
         end else begin
            rdata <= mem[raddr];
         end
      end
   end else begin : g_rd_comb
      assign rdata = mem[raddr];
   end

   a_r4_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq
   import edid_fetch_pkg::*;
#(
   parameter int unsigned CHUNK_BYTES    = 16,
   parameter int unsigned MAX_EXT        = 4,
   parameter int unsigned RETRIES        = 2,
   parameter int unsigned TIMEOUT_US     = 200000,
   parameter int unsigned CYC_PER_US     = 125,
   parameter bit          STORE_REG_READ = 1'b1,
   localparam int unsigned EXT_W  = $clog2(MAX_EXT + 1),
   localparam int unsigned ADDR_W = EXT_W + 7,
   localparam int unsigned LEN_W  = $clog2(CHUNK_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic [1:0]        status,
   output logic [EXT_W-1:0]  ext_count,
   output logic              fifo_clear,
   output logic              cmd_valid,
   output logic [7:0]        cmd_segment,
   output logic [7:0]        cmd_offset,
   output logic [LEN_W-1:0]  cmd_len,
   input  logic              eng_busy,
   output logic              fifo_rd,
   input  logic [7:0]        fifo_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);

   localparam int unsigned DEPTH      = (MAX_EXT + 1) * EDID_BLOCK_BYTES;
   localparam int unsigned RETRY_W    = $clog2(RETRIES + 2);
   localparam int unsigned WAIT_LIMIT = TIMEOUT_US * CYC_PER_US;

   if (CHUNK_BYTES < 1 || CHUNK_BYTES > EDID_BLOCK_BYTES) begin : g_bad_chunk
      $error("edid_fetch_seq: CHUNK_BYTES out of range");
   end
   if (MAX_EXT < 1 || MAX_EXT > 15) begin : g_bad_ext
      $error("edid_fetch_seq: MAX_EXT out of range");
   end
   if (CYC_PER_US < 1 || TIMEOUT_US < 1) begin : g_bad_time
      $error("edid_fetch_seq: timeout parameters must be nonzero");
   end

   seq_state_e         state;
   logic [EXT_W-1:0]   blk;
   logic [6:0]         in_blk;
   logic [RETRY_W-1:0] retry;
   logic [7:0]         sum;
   logic [LEN_W-1:0]   left;
   logic [7:0]         ext_raw;
   logic [EXT_W-1:0]   ext_target;
   logic [EXT_W-1:0]   ext_got;
   logic               done_q;
   fetch_status_e      status_q;

   logic [ADDR_W-1:0]  byte_addr;
   logic [LEN_W-1:0]   chunk_len;
   logic               wait_expired;

   assign byte_addr = {blk, in_blk};

   edid_cmd_former #(
      .ADDR_W      (ADDR_W),
      .LEN_W       (LEN_W),
      .CHUNK_BYTES (CHUNK_BYTES)
   ) u_former (
      .byte_addr (byte_addr),
      .in_block  (in_blk),
      .segment   (cmd_segment),
      .offset    (cmd_offset),
      .len       (chunk_len)
   );

   edid_wait_timer #(
      .LIMIT (WAIT_LIMIT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == SQ_WAIT),
      .expired (wait_expired)
   );

   edid_block_store #(
      .DEPTH    (DEPTH),
      .AW       (ADDR_W),
      .REG_READ (STORE_REG_READ)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (state == SQ_DRAIN),
      .waddr (byte_addr),
      .wdata (fifo_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   assign fifo_clear = (state == SQ_CLEAR);
   assign cmd_valid  = (state == SQ_ISSUE);
   assign fifo_rd    = (state == SQ_DRAIN);
   assign cmd_len    = chunk_len;
   assign done       = done_q;
   assign status     = status_q;
   assign ext_count  = ext_got;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SQ_IDLE;
         blk        <= '0;
         in_blk     <= '0;
         retry      <= '0;
         sum        <= '0;
         left       <= '0;
         ext_raw    <= '0;
         ext_target <= '0;
         ext_got    <= '0;
         done_q     <= 1'b0;
         status_q   <= FETCH_OK;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               if (start) begin
                  blk     <= '0;
                  in_blk  <= '0;
                  retry   <= '0;
                  sum     <= '0;
                  ext_got <= '0;
                  state   <= SQ_CLEAR;
               end
            end
            SQ_CLEAR: begin
               state <= SQ_ISSUE;
            end
            SQ_ISSUE: begin
               left  <= chunk_len;
               state <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (!eng_busy) begin
                  state <= SQ_DRAIN;
               end else if (wait_expired) begin
                  status_q <= FETCH_TIMEOUT;
                  done_q   <= 1'b1;
                  state    <= SQ_IDLE;
               end
            end
            SQ_DRAIN: begin
               sum    <= sum + fifo_data;
               in_blk <= in_blk + 7'd1;
               left   <= left - LEN_W'(1);
               if (blk == '0 && in_blk == 7'(EXT_COUNT_INDEX)) begin
                  ext_raw <= fifo_data;
               end
               if (left == LEN_W'(1)) begin
                  state <= (in_blk == 7'd127) ? SQ_CHECK : SQ_CLEAR;
               end
            end
            SQ_CHECK: begin
               sum <= '0;
               if (sum == 8'd0) begin
                  retry <= '0;
                  if (blk == '0) begin
                     if (ext_raw == 8'd0) begin
                        status_q <= FETCH_OK;
                        done_q   <= 1'b1;
                        state    <= SQ_IDLE;
                     end else begin
                        ext_target <= (ext_raw > 8'(MAX_EXT)) ? EXT_W'(MAX_EXT)
                                                              : EXT_W'(ext_raw);
                        blk        <= blk + EXT_W'(1);
                        state      <= SQ_CLEAR;
                     end
                  end else begin
                     ext_got <= blk;
                     if (blk == ext_target) begin
                        status_q <= FETCH_OK;
                        done_q   <= 1'b1;
                        state    <= SQ_IDLE;
                     end else begin
                        blk   <= blk + EXT_W'(1);
                        state <= SQ_CLEAR;
                     end
                  end
               end else if (retry < RETRY_W'(RETRIES)) begin
                  retry <= retry + RETRY_W'(1);
                  state <= SQ_CLEAR;
               end else begin
                  status_q <= (blk == '0) ? FETCH_CSUM_BAD : FETCH_OK;
                  done_q   <= 1'b1;
                  state    <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   a_r1_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_len != '0 && cmd_len <= LEN_W'(CHUNK_BYTES)));

   a_r2_clear_precedes_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(fifo_clear));

   a_r4_no_pop_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> !eng_busy);

   a_r7_csum_fail_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == FETCH_CSUM_BAD) |-> (ext_count == '0));

   a_r8_ext_clamped: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ext_count <= EXT_W'(MAX_EXT)));

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/edid_fetch_seq_test.sv
module edid_fetch_seq_test;

   localparam int EXT_W  = 3;
   localparam int ADDR_W = 10;
   localparam int LEN_W  = 5;
   localparam int NBLK   = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              done;
   logic [1:0]        status;
   logic [EXT_W-1:0]  ext_count;
   logic              fifo_clear;
   logic              cmd_valid;
   logic [7:0]        cmd_segment;
   logic [7:0]        cmd_offset;
   logic [LEN_W-1:0]  cmd_len;
   logic              eng_busy;
   logic              fifo_rd;
   logic [7:0]        fifo_data;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [7:0]        rd_data;

   always #4 clk = ~clk;

   edid_fetch_seq #(
      .CHUNK_BYTES    (16),
      .MAX_EXT        (4),
      .RETRIES        (2),
      .TIMEOUT_US     (4),
      .CYC_PER_US     (5),
      .STORE_REG_READ (1'b1)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .done        (done),
      .status      (status),
      .ext_count   (ext_count),
      .fifo_clear  (fifo_clear),
      .cmd_valid   (cmd_valid),
      .cmd_segment (cmd_segment),
      .cmd_offset  (cmd_offset),
      .cmd_len     (cmd_len),
      .eng_busy    (eng_busy),
      .fifo_rd     (fifo_rd),
      .fifo_data   (fifo_data),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- engine model ----------------
   logic [7:0] image [NBLK*128];
   int  corrupt_left [NBLK];
   bit  bad_pass [NBLK];
   bit  hang = 1'b0;
   int  eng_delay = 3;
   int  bcnt = 0;
   logic [7:0] fq [$];

   always @(posedge clk) begin
      if (!rst_n) begin
         eng_busy  <= 1'b0;
         fifo_data <= 8'h00;
         fq.delete();
         bcnt = 0;
      end else begin
         if (fifo_rd && fq.size() > 0) void'(fq.pop_front());
         if (fifo_clear) fq.delete();
         if (cmd_valid) begin
            int a;
            int bk;
            a  = int'(cmd_segment) * 256 + int'(cmd_offset);
            bk = a / 128;
            if (a % 128 == 0) begin
               bad_pass[bk] = (corrupt_left[bk] > 0);
               if (corrupt_left[bk] > 0) corrupt_left[bk]--;
            end
            for (int i = 0; i < int'(cmd_len); i++) begin
               logic [7:0] b;
               b = image[a + i];
               if (bad_pass[bk] && ((a + i) % 128 == 5)) b = b ^ 8'h01;
               fq.push_back(b);
            end
            eng_busy <= 1'b1;
            bcnt = eng_delay;
         end else if (eng_busy && !hang) begin
            if (bcnt == 0) eng_busy <= 1'b0;
            else bcnt--;
         end
         fifo_data <= (fq.size() > 0) ? fq[0] : 8'h00;
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct { int addr; int len; } cmd_t;
   cmd_t exp_cmds [$];
   int   exp_status = 0;
   int   exp_ext = 0;
   bit   got_done = 1'b0;
   bit   prev_clear = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_valid) begin
            int a;
            a = int'(cmd_segment) * 256 + int'(cmd_offset);
            chk(prev_clear, "R2", "fifo_clear before command", int'(prev_clear), 1);
            if (exp_cmds.size() == 0) begin
               chk(1'b0, "R1", "unexpected command at address", a, -1);
            end else begin
               cmd_t e;
               e = exp_cmds.pop_front();
               chk(a == e.addr, "R3", "command byte address", a, e.addr);
               chk(int'(cmd_len) == e.len, "R1", "command length", int'(cmd_len), e.len);
            end
         end
         if (done) begin
            got_done = 1'b1;
            chk(int'(status) == exp_status, "R5 R7 R9", "status", int'(status), exp_status);
            chk(int'(ext_count) == exp_ext, "R8 R9", "ext_count", int'(ext_count), exp_ext);
         end
         prev_clear = fifo_clear;
      end
   end

   // ---------------- driver ----------------
   function automatic logic [7:0] pat(int k, int i);
      return 8'((i * 7 + k * 29 + 3) & 255);
   endfunction

   task automatic build_image(input int ext_byte);
      for (int k = 0; k < NBLK; k++) begin
         int s;
         s = 0;
         for (int i = 0; i < 127; i++) begin
            image[k*128 + i] = pat(k, i);
            if (k == 0 && i == 126) image[i] = 8'(ext_byte);
            s += int'(image[k*128 + i]);
         end
         image[k*128 + 127] = 8'((256 - (s % 256)) % 256);
      end
   endtask

   task automatic push_block(input int k, input int attempts);
      for (int a = 0; a < attempts; a++)
         for (int j = 0; j < 8; j++) begin
            cmd_t c;
            c.addr = k * 128 + j * 16;
            c.len  = 16;
            exp_cmds.push_back(c);
         end
   endtask

   task automatic run_case(input string name, input int ext_byte,
                           input int c0, input int c1, input int c2,
                           input int c3, input int c4,
                           input int delay, input bit stall, input bit expect_tmo);
      int cs [NBLK];
      cs = '{c0, c1, c2, c3, c4};
      build_image(ext_byte);
      for (int k = 0; k < NBLK; k++) begin
         corrupt_left[k] = cs[k];
         bad_pass[k] = 1'b0;
      end
      eng_delay = delay;
      hang = stall;
      exp_cmds.delete();
      if (expect_tmo) begin
         cmd_t c;
         c.addr = 0;
         c.len  = 16;
         exp_cmds.push_back(c);
         exp_status = 1;
         exp_ext = 0;
      end else begin
         push_block(0, (cs[0] >= 3) ? 3 : cs[0] + 1);
         if (cs[0] >= 3) begin
            exp_status = 2;
            exp_ext = 0;
         end else begin
            int n;
            n = (ext_byte > 4) ? 4 : ext_byte;
            exp_status = 0;
            exp_ext = n;
            for (int k = 1; k <= n; k++) begin
               push_block(k, (cs[k] >= 3) ? 3 : cs[k] + 1);
               if (cs[k] >= 3) begin
                  exp_ext = k - 1;
                  break;
               end
            end
         end
      end
      got_done = 1'b0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t < 30000 && !got_done; t++) @(negedge clk);
      chk(got_done, "R10", {name, ": done seen"}, int'(got_done), 1);
      repeat (3) @(negedge clk);
      chk(exp_cmds.size() == 0, "R1", {name, ": commands left unissued"},
          exp_cmds.size(), 0);
      hang = 1'b0;
      for (int t = 0; t < 100 && eng_busy; t++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic check_byte(input int addr, input logic [7:0] exp, input string req);
      @(negedge clk);
      rd_addr = ADDR_W'(addr);
      @(negedge clk);
      chk(rd_data == exp, req, $sformatf("stored byte @%0d", addr),
          int'(rd_data), int'(exp));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10 reset state
      chk(done == 1'b0, "R10", "done after reset", int'(done), 0);
      chk(cmd_valid == 1'b0 && fifo_clear == 1'b0 && fifo_rd == 1'b0, "R10",
          "strobes after reset", int'({cmd_valid, fifo_clear, fifo_rd}), 0);
      chk(ext_count == '0 && status == 2'd0, "R10", "ext_count/status after reset",
          int'({ext_count, status}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R3 R4: base only
      run_case("base only", 0, 0, 0, 0, 0, 0, 3, 1'b0, 1'b0);
      check_byte(0, image[0], "R4");
      check_byte(126, 8'd0, "R4");
      check_byte(127, image[127], "R4");

      // R8 two extensions; block 2 at segment 1
      run_case("two ext", 2, 0, 0, 0, 0, 0, 3, 1'b0, 1'b0);
      check_byte(256, image[256], "R3");
      check_byte(383, image[383], "R4");

      // R8 clamp 9 -> 4
      run_case("clamp", 9, 0, 0, 0, 0, 0, 1, 1'b0, 1'b0);
      check_byte(639, image[639], "R8");
      check_byte(126, 8'd9, "R8");

      // R6 one base retry
      run_case("base retry", 0, 1, 0, 0, 0, 0, 2, 1'b0, 1'b0);
      check_byte(5, image[5], "R6");

      // R7 base exhausts retries
      run_case("base fail", 1, 3, 0, 0, 0, 0, 2, 1'b0, 1'b0);

      // R9 extension 2 fails -> count 1
      run_case("ext fail", 3, 0, 0, 3, 0, 0, 2, 1'b0, 1'b0);
      check_byte(256 + 5, image[256 + 5] ^ 8'h01, "R6");

      // R6 extension recovers on last retry
      run_case("ext retry", 1, 0, 2, 0, 0, 0, 2, 1'b0, 1'b0);
      check_byte(128 + 5, image[128 + 5], "R6");

      // R5 boundary: longest accepted busy
      run_case("slow ok", 0, 0, 0, 0, 0, 0, 18, 1'b0, 1'b0);
      // R5 one cycle more -> timeout
      run_case("slow tmo", 0, 0, 0, 0, 0, 0, 19, 1'b0, 1'b1);
      // R5 stalled engine
      run_case("stall", 2, 0, 0, 0, 0, 0, 3, 1'b1, 1'b1);

      // R10 normal fetch after a timeout
      run_case("recover", 1, 0, 0, 0, 0, 0, 3, 1'b0, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule